// File: doc/BRIEF.md
# Cascaded 32-bit Capture Timer

This block builds one wide timestamp counter out of two equal halves. The lower half advances on every clock while the block is enabled. Each time the lower half wraps, it sends a registered carry pulse that advances the upper half. A falling edge on an external pin passes through a synchroniser and becomes a single capture pulse. That pulse latches the lower half at once and the upper half one cycle later. A carry that lands at the same moment as the capture is therefore already counted when the upper half is sampled.

The captured word is the upper capture above the lower capture. A sticky flag reports each completed capture, and software clears it. A separate buffer-full state holds the stored word until a read strobe frees it. A capture that arrives while the buffer is still full is dropped and raises a one-cycle error pulse. A one-cycle overflow pulse marks the wrap of the full combined counter.

Top module: `cascade_capture_timer`

## Requirements
- R1: While `enable` is low the lower half holds its value. A capture taken during that time returns the same value as the last count reached while enabled.
- R2: The captured value equals the number of rising clock edges with `enable` high since reset, modulo 2^(2*HALF_W). The upper half advances exactly once per wrap of the lower half.
- R3: The pin passes through two synchroniser flip-flops. If the pin goes low just before rising edge k, the lower half is latched as it stands just before edge k+2. `cap_flag` and the complete `cap_value` are visible after edge k+3.
- R4: One falling edge yields exactly one capture. Holding the pin low and returning it high trigger nothing further.
- R5: When a capture coincides with a lower-half wrap (lower capture 0 or all ones), the upper capture is consistent with the lower one.
- R6: `cap_flag` (1 = capture done) is set by each completed capture. It stays set until `cap_flag_clr` is pulsed.
- R7: The buffer stays full after a capture until `cap_read` is pulsed. A capture arriving while it is full is dropped: `err_evt` pulses for one cycle, `cap_value` keeps the old word, and `cap_flag` is not set.
- R8: `ovf_evt` pulses for exactly one cycle each time the combined counter wraps from all ones to zero.
- R9: After an active-low reset, `cap_value` is zero and `cap_flag`, `ovf_evt` and `err_evt` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Lets the lower half count |
| cap_pin | input | 1 | Asynchronous capture pin; a falling edge triggers capture |
| cap_read | input | 1 | Pulse that frees the capture buffer |
| cap_flag_clr | input | 1 | Pulse that clears `cap_flag` |
| cap_value | output | 2*HALF_W | Captured word, upper half above lower half |
| cap_flag | output | 1 | Sticky capture-done flag |
| ovf_evt | output | 1 | One-cycle pulse on combined counter wrap |
| err_evt | output | 1 | One-cycle pulse when a capture is lost |

## Verification
The bench builds the block with HALF_W = 4. The lower half then wraps every 16 cycles and the combined counter every 256. This brings carries coincident with captures, many upper-half steps and a full wrap with its overflow pulse within a few hundred cycles. The synchroniser keeps its default depth of two, so the capture latency stays fixed at the edges named in R3.

// File: rtl/cascade_capture_timer.sv
module cascade_capture_timer #(
  parameter int HALF_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  cap_pin,
  input  logic                  cap_read,
  input  logic                  cap_flag_clr,
  output logic [2*HALF_W-1:0]   cap_value,
  output logic                  cap_flag,
  output logic                  ovf_evt,
  output logic                  err_evt
);
  localparam logic [HALF_W-1:0] HALF_MAX = '1;

  logic [SYNC_STAGES:0] sync_q;
  logic [HALF_W-1:0]    lo_cnt, hi_cnt, cap_lo, cap_hi;
  logic                 carry_q, hi_pend, buf_full;
  logic                 cap_evt, take;

  // pin synchroniser plus one stage for edge detection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], cap_pin};

  assign cap_evt = sync_q[SYNC_STAGES] & ~sync_q[SYNC_STAGES-1];
  assign take    = cap_evt & (~buf_full | cap_read);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_cnt  <= '0;
      carry_q <= 1'b0;
    end else begin
      carry_q <= enable && (lo_cnt == HALF_MAX);
      if (enable) lo_cnt <= lo_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_cnt  <= '0;
      ovf_evt <= 1'b0;
    end else begin
      ovf_evt <= carry_q && (hi_cnt == HALF_MAX);
      if (carry_q) hi_cnt <= hi_cnt + 1'b1;
    end

  // lower half latched on the event, upper half one cycle later
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_lo   <= '0;
      cap_hi   <= '0;
      hi_pend  <= 1'b0;
      buf_full <= 1'b0;
      cap_flag <= 1'b0;
      err_evt  <= 1'b0;
    end else begin
      hi_pend <= take;
      err_evt <= cap_evt & ~take;
      if (take)    cap_lo <= lo_cnt;
      if (hi_pend) cap_hi <= hi_cnt;
      if (hi_pend)       buf_full <= 1'b1;
      else if (cap_read) buf_full <= 1'b0;
      if (hi_pend)           cap_flag <= 1'b1;
      else if (cap_flag_clr) cap_flag <= 1'b0;
    end

  assign cap_value = {cap_hi, cap_lo};

  assert_lo_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(lo_cnt));
  assert_hi_on_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_q |=> $stable(hi_cnt));
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt);
  assert_flag_with_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> buf_full);
  assert_lost_keeps_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> $stable(cap_lo));
  assert_ovf_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !ovf_evt);
endmodule

// File: tb/test_cascade_capture_timer.sv
module test_cascade_capture_timer;
  localparam int HW = 4;
  localparam int FW = 2 * HW;
  localparam int NGAP = 8;
  localparam int GAPS [NGAP] = '{3, 7, 11, 13, 16, 19, 21, 29};

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, cap_pin = 1'b1;
  logic cap_read = 1'b0, cap_flag_clr = 1'b0;
  logic [FW-1:0] cap_value;
  logic cap_flag, ovf_evt, err_evt;

  int total = 0, failed = 0;
  int ecnt = 0, err_cnt = 0, ovf_cnt = 0;
  int snap, base, errs0;
  logic [FW-1:0] keep;

  cascade_capture_timer #(.HALF_W(HW)) i_cascade_capture_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cap_pin(cap_pin),
    .cap_read(cap_read), .cap_flag_clr(cap_flag_clr), .cap_value(cap_value),
    .cap_flag(cap_flag), .ovf_evt(ovf_evt), .err_evt(err_evt));

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecnt <= 0;
    else if (enable) ecnt <= ecnt + 1;

  always @(negedge clk) begin
    if (err_evt) err_cnt++;
    if (ovf_evt) ovf_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fall_pin();
    @(negedge clk);
    cap_pin = 1'b0;
    snap = ecnt + (enable ? 2 : 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic rise_pin();
    cap_pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_buf();
    cap_read = 1'b1; cap_flag_clr = 1'b1;
    @(negedge clk);
    cap_read = 1'b0; cap_flag_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 value", int'(cap_value), 0);
    chk("R9 flag", int'(cap_flag), 0);
    chk("R9 ovf", int'(ovf_evt), 0);
    chk("R9 err", int'(err_evt), 0);
    rst_n = 1'b1;
    enable = 1'b1;

    for (int i = 0; i < NGAP; i++) begin
      repeat (GAPS[i]) @(negedge clk);
      fall_pin();
      chk("R3 flag set", int'(cap_flag), 1);
      chk("R2 value", int'(cap_value), snap % 256);
      rise_pin();
      release_buf();
      chk("R6 flag cleared", int'(cap_flag), 0);
    end

    // R5: captures right at a lower-half wrap
    for (int t = 0; t < 2; t++) begin
      while (((ecnt + 3) % 16) != (t == 0 ? 0 : 15)) @(negedge clk);
      fall_pin();
      chk("R5 carry coincident", int'(cap_value), snap % 256);
      chk("R5 low part", int'(cap_value[HW-1:0]), t == 0 ? 0 : 15);
      rise_pin();
      release_buf();
    end

    // R4: held low then released, no extra capture
    errs0 = err_cnt;
    fall_pin();
    release_buf();
    repeat (6) @(negedge clk);
    chk("R4 held low", int'(cap_flag), 0);
    rise_pin();
    repeat (6) @(negedge clk);
    chk("R4 rising edge", int'(cap_flag), 0);
    chk("R4 no error", err_cnt - errs0, 0);

    // R7: lost capture while buffer full
    fall_pin();
    keep = cap_value;
    rise_pin();
    cap_flag_clr = 1'b1; @(negedge clk); cap_flag_clr = 1'b0;
    errs0 = err_cnt;
    repeat (5) @(negedge clk);
    fall_pin();
    chk("R7 error pulse", err_cnt - errs0, 1);
    chk("R7 value kept", int'(cap_value), int'(keep));
    chk("R7 flag not set", int'(cap_flag), 0);
    rise_pin();
    release_buf();
    fall_pin();
    chk("R7 after read", int'(cap_value), snap % 256);
    chk("R7 no error after read", err_cnt - errs0, 1);
    rise_pin();
    release_buf();

    // R1: disabled counter holds
    enable = 1'b0;
    fall_pin();
    keep = cap_value;
    chk("R1 disabled capture", int'(cap_value), snap % 256);
    rise_pin();
    release_buf();
    repeat (10) @(negedge clk);
    fall_pin();
    chk("R1 still held", int'(cap_value), int'(keep));
    rise_pin();
    release_buf();

    // R8: full wrap after fresh reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    base = ovf_cnt;
    enable = 1'b1;
    while (ecnt < 300) @(negedge clk);
    chk("R8 one wrap pulse", ovf_cnt - base, 1);
    chk("R8 quiet after", int'(ovf_evt), 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule